// File: doc/BRIEF.md
# EDO DRAM Strobe-Level Device Model

This block behaves like the device side of a 16-bit extended-data-out DRAM so that a memory controller can be verified against it in a synchronous fabric. It oversamples the active-low row strobe, the two byte-lane column strobes, the write enable, the output enable and a multiplexed 8-bit address on a fast clock. From the order in which the strobe edges arrive, it sorts each access into one of several kinds: standby, word or byte read, early write, page-mode column access, row-only refresh, or column-before-row refresh.

Data sits in a small parameterized array indexed by {row, column}. Each byte lane has its own output enable, and each is gated by that lane's column strobe. An internal row counter supplies the row for refreshes that are started with a column strobe already low. A refresh watcher marks every row that is refreshed or opened. At the end of each fixed window of clock cycles it sets a sticky flag if any row went unmarked during that window.

The row width is the full address width, so the refresh counter spans every row. The column width is reduced by a parameter so that the storage stays small.

Top module: `edo_dram_model`

## Requirements
- R1: With the row strobe and both column strobes high, both lanes are high-impedance (dq_oe = 2'b00). This is also the state after reset. A rising row strobe closes the open row.
- R2: If a column strobe is low in the sample before the row strobe falls, the access is a counter refresh. The address is ignored. Column strobe activity before the next row strobe rise neither writes nor reads the array, and a lane with no held read data stays high-impedance.
- R3: If the row strobe falls while both column strobes are high, row addr[ROW_W-1:0] is marked as refreshed and both lanes stay high-impedance.
- R4: The lane enables are dq_oe[1] for the upper lane (dq_out[15:8], gated by ucas_n) and dq_oe[0] for the lower lane (dq_out[7:0], gated by lcas_n). A lane is enabled only while its column strobe is low, oe_n is low and read data is held. Pin changes reach dq_oe within two clock edges.
- R5: If we_n is low when a column strobe falls in an open row, the access is an early write of dq_in. Only the lanes whose column strobes are low are written, and any held read data is dropped.
- R6: Each column strobe fall while the row strobe stays low latches addr[COL_W-1:0] as a new column in the open row. The word accessed is array[{row, column}].
- R7: In a hidden refresh, the column strobes stay low while the row strobe rises and falls again. The read data keeps being driven throughout, and the second fall is handled as a counter refresh.
- R8: The refresh counter is ROW_W bits wide. It starts at 0, advances by one after each counter refresh, and wraps from its maximum to 0.
- R9: refresh_miss rises at the end of a WIN_CYCLES window in which at least one row was not marked, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 16 | Write data from the controller |
| dq_out | output | 16 | Read data, zero on a disabled lane |
| dq_oe | output | 2 | Per-lane output enable, bit 1 upper |
| refresh_miss | output | 1 | Sticky flag: a row missed a refresh window |

## Verification
The bench reads a word one lane at a time and writes single lanes. A design that shares one enable between both lanes would drive the idle lane, and one that writes the full word on a byte write would corrupt the other byte. It also drops and re-raises a column strobe with write enabled during a counter refresh, then reads the word back; a design that decodes the row strobe alone would overwrite stored data. A hidden refresh checks that the data stays on the pins while the row strobe toggles. Refresh windows are covered by splitting rows between counter and row-only refreshes across three windows. A counter that restarted per window, or that failed to wrap, would leave rows unmarked and raise the miss flag too early.

// File: rtl/edo_pkg.sv
package edo_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef struct packed {
        logic             ras_n;
        logic [LANES-1:0] cas_n;   // [1] upper lane, [0] lower lane
        logic             we_n;
        logic             oe_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = strobe_t'('1);

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_ROW  = 2'd1,
        CYC_CBR  = 2'd2
    } cyc_state_e;

    typedef struct packed {
        logic             en;
        logic             wr;
        logic [LANES-1:0] lanes;
    } col_access_t;

    function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] sel);
        logic [DATA_W-1:0] m;
        for (int l = 0; l < LANES; l++) begin
            m[l*LANE_W +: LANE_W] = {LANE_W{sel[l]}};
        end
        return m;
    endfunction
endpackage

// File: rtl/edo_strobe_sync.sv
module edo_strobe_sync
    import edo_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           pins_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    output strobe_t           cur_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] din_o,
    output logic              ras_fall_o,
    output logic              ras_rise_o,
    output logic [LANES-1:0]  cas_fall_o,
    output logic              cas_pre_low_o
);
    logic             prv_ras;
    logic [LANES-1:0] prv_cas;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_o   <= STROBE_IDLE;
            prv_ras <= 1'b1;
            prv_cas <= '1;
            addr_o  <= '0;
            din_o   <= '0;
        end else begin
            cur_o   <= pins_i;
            prv_ras <= cur_o.ras_n;
            prv_cas <= cur_o.cas_n;
            addr_o  <= addr_i;
            din_o   <= din_i;
        end
    end

    assign ras_fall_o    = prv_ras & ~cur_o.ras_n;
    assign ras_rise_o    = ~prv_ras & cur_o.ras_n;
    assign cas_fall_o    = prv_cas & ~cur_o.cas_n;
    assign cas_pre_low_o = ~&prv_cas;
endmodule

// File: rtl/edo_cycle_fsm.sv
module edo_cycle_fsm
    import edo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ROW_W  = 8,
    parameter int COL_W  = 3,
    localparam int IDX_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           cur_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ras_fall_i,
    input  logic              ras_rise_i,
    input  logic [LANES-1:0]  cas_fall_i,
    input  logic              cas_pre_low_i,
    output col_access_t       acc_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              mark_en_o,
    output logic [ROW_W-1:0]  mark_row_o
);
    cyc_state_e       state;
    logic [ROW_W-1:0] open_row;
    logic [ROW_W-1:0] ref_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CYC_IDLE;
            open_row <= '0;
            ref_cnt  <= '0;
        end else if (ras_fall_i) begin
            if (cas_pre_low_i) begin
                state   <= CYC_CBR;
                ref_cnt <= ref_cnt + 1'b1;
            end else begin
                state    <= CYC_ROW;
                open_row <= addr_i[ROW_W-1:0];
            end
        end else if (ras_rise_i) begin
            state <= CYC_IDLE;
        end
    end

    always_comb begin
        acc_o.en    = (state == CYC_ROW) && !cur_i.ras_n && (|cas_fall_i);
        acc_o.wr    = !cur_i.we_n;
        acc_o.lanes = ~cur_i.cas_n;
        idx_o       = {open_row, addr_i[COL_W-1:0]};
        mark_en_o   = ras_fall_i;
        mark_row_o  = cas_pre_low_i ? ref_cnt : addr_i[ROW_W-1:0];
    end

    // R1: a rising row strobe always leaves the row closed
    p_ras_rise_idle_r1: assert property (@(posedge clk) disable iff (rst)
        ras_rise_i |=> state == CYC_IDLE)
        else $error("row not closed after row strobe rise");

    // R8: each counter refresh advances the counter by one, with wrap
    p_cbr_count_r8: assert property (@(posedge clk) disable iff (rst)
        (ras_fall_i && cas_pre_low_i) |=> ref_cnt == ROW_W'($past(ref_cnt) + 1'b1))
        else $error("refresh counter step wrong");
endmodule

// File: rtl/edo_array.sv
module edo_array
    import edo_pkg::*;
#(
    parameter int IDX_W = 11,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  col_access_t       acc_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              cas_idle_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              rd_held_o
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] wmask;

    assign wmask = lane_bits(acc_i.lanes);

    always_ff @(posedge clk) begin
        if (acc_i.en && acc_i.wr) begin
            mem[idx_i] <= (mem[idx_i] & ~wmask) | (din_i & wmask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_o    <= '0;
            rd_held_o <= 1'b0;
        end else if (acc_i.en && !acc_i.wr) begin
            dout_o    <= mem[idx_i];
            rd_held_o <= 1'b1;
        end else if ((acc_i.en && acc_i.wr) || cas_idle_i) begin
            rd_held_o <= 1'b0;
        end
    end

    // R5: a write access drops any held read data
    p_write_drops_read_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_i.en && acc_i.wr) |=> !rd_held_o)
        else $error("read data still held after write");
endmodule

// File: rtl/edo_refresh_watch.sv
module edo_refresh_watch #(
    parameter int ROW_W      = 8,
    parameter int WIN_CYCLES = 4096,
    localparam int ROWS  = 1 << ROW_W,
    localparam int CNT_W = $clog2(WIN_CYCLES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mark_en_i,
    input  logic [ROW_W-1:0] mark_row_i,
    output logic             miss_o
);
    logic [ROWS-1:0]  seen;
    logic [ROWS-1:0]  mark_vec;
    logic [CNT_W-1:0] win_cnt;

    always_comb begin
        mark_vec = '0;
        if (mark_en_i) mark_vec[mark_row_i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen    <= '0;
            win_cnt <= '0;
            miss_o  <= 1'b0;
        end else if (win_cnt == CNT_W'(WIN_CYCLES - 1)) begin
            win_cnt <= '0;
            seen    <= '0;
            miss_o  <= miss_o | ~&(seen | mark_vec);
        end else begin
            win_cnt <= win_cnt + 1'b1;
            seen    <= seen | mark_vec;
        end
    end

    // R9: the miss flag is sticky
    p_miss_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        miss_o |=> miss_o)
        else $error("refresh miss flag cleared");
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model
    import edo_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int COL_W      = 3,
    parameter int WIN_CYCLES = 4096,
    localparam int ROW_W = ADDR_W,
    localparam int IDX_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              ucas_n,
    input  logic              lcas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [1:0]        dq_oe,
    output logic              refresh_miss
);
    strobe_t           pins, cur;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q, dout;
    logic              ras_fall, ras_rise, cas_pre_low, rd_held;
    logic [LANES-1:0]  cas_fall;
    col_access_t       acc;
    logic [IDX_W-1:0]  idx;
    logic              mark_en;
    logic [ROW_W-1:0]  mark_row;

    assign pins = '{ras_n: ras_n, cas_n: {ucas_n, lcas_n}, we_n: we_n, oe_n: oe_n};

    edo_strobe_sync #(.ADDR_W(ADDR_W)) u_sync (
        .clk(clk), .rst(rst), .pins_i(pins), .addr_i(addr), .din_i(dq_in),
        .cur_o(cur), .addr_o(addr_q), .din_o(din_q),
        .ras_fall_o(ras_fall), .ras_rise_o(ras_rise),
        .cas_fall_o(cas_fall), .cas_pre_low_o(cas_pre_low)
    );

    edo_cycle_fsm #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
        .clk(clk), .rst(rst), .cur_i(cur), .addr_i(addr_q),
        .ras_fall_i(ras_fall), .ras_rise_i(ras_rise),
        .cas_fall_i(cas_fall), .cas_pre_low_i(cas_pre_low),
        .acc_o(acc), .idx_o(idx), .mark_en_o(mark_en), .mark_row_o(mark_row)
    );

    edo_array #(.IDX_W(IDX_W)) u_array (
        .clk(clk), .rst(rst), .acc_i(acc), .idx_i(idx), .din_i(din_q),
        .cas_idle_i(&cur.cas_n), .dout_o(dout), .rd_held_o(rd_held)
    );

    edo_refresh_watch #(.ROW_W(ROW_W), .WIN_CYCLES(WIN_CYCLES)) u_watch (
        .clk(clk), .rst(rst), .mark_en_i(mark_en), .mark_row_i(mark_row),
        .miss_o(refresh_miss)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign dq_oe[l] = rd_held & ~cur.cas_n[l] & ~cur.oe_n;
        assign dq_out[l*LANE_W +: LANE_W] = dq_oe[l] ? dout[l*LANE_W +: LANE_W] : '0;
    end

    // R1: full standby leaves both lanes undriven
    p_standby_z_r1: assert property (@(posedge clk) disable iff (rst)
        $past(ras_n && ucas_n && lcas_n) |-> dq_oe == 2'b00)
        else $error("lane driven in standby");

    // R4: each lane is gated by its own column strobe
    p_upper_z_r4: assert property (@(posedge clk) disable iff (rst)
        $past(ucas_n) |-> !dq_oe[1])
        else $error("upper lane driven with its strobe high");

    p_lower_z_r4: assert property (@(posedge clk) disable iff (rst)
        $past(lcas_n) |-> !dq_oe[0])
        else $error("lower lane driven with its strobe high");

    p_oe_gate_r4: assert property (@(posedge clk) disable iff (rst)
        $past(oe_n) |-> dq_oe == 2'b00)
        else $error("lane driven with output enable high");
endmodule

// File: tb/edo_dram_model_tb_top.sv
module edo_dram_model_tb_top;
    localparam int WIN = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [7:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic        refresh_miss;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    bit done    = 0;

    typedef struct {
        string       tag;
        bit          io_chk;
        logic [1:0]  oe;
        logic [15:0] dq;
        bit          miss_chk;
        logic        miss;
    } exp_t;

    exp_t sb_q[$];

    edo_dram_model #(.ADDR_W(8), .COL_W(3), .WIN_CYCLES(WIN)) dut_i (
        .clk(clk), .rst(rst), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .refresh_miss(refresh_miss)
    );

    always #4 clk = ~clk;

    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    // monitor: pops expected items and compares away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t it;
                logic [15:0] m;
                it = sb_q.pop_front();
                vectors++;
                m = {{8{it.oe[1]}}, {8{it.oe[0]}}};
                if (it.io_chk && (dq_oe !== it.oe || (dq_out & m) !== (it.dq & m))) begin
                    fails++;
                    $display("FAIL %s: oe=%b dq=%h expected oe=%b dq=%h",
                             it.tag, dq_oe, dq_out & m, it.oe, it.dq & m);
                end
                if (it.miss_chk && refresh_miss !== it.miss) begin
                    fails++;
                    $display("FAIL %s: refresh_miss=%b expected %b", it.tag, refresh_miss, it.miss);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pins(input logic r, input logic [1:0] c, input logic w, input logic o,
                        input logic [7:0] a, input logic [15:0] d);
        ras_n = r; ucas_n = c[1]; lcas_n = c[0]; we_n = w; oe_n = o; addr = a; dq_in = d;
    endtask

    task automatic expect_io(input string tag, input logic [1:0] oe, input logic [15:0] dq);
        exp_t it;
        it.tag = tag; it.io_chk = 1; it.oe = oe; it.dq = dq; it.miss_chk = 0; it.miss = 0;
        sb_q.push_back(it);
        tick(1);
    endtask

    task automatic expect_miss(input string tag, input logic miss);
        exp_t it;
        it.tag = tag; it.io_chk = 0; it.oe = 0; it.dq = 0; it.miss_chk = 1; it.miss = miss;
        sb_q.push_back(it);
        tick(1);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic cbr_refresh();
        pins(1, 2'b00, 1, 1, 8'hA7, 16'h0); tick(2);
        pins(0, 2'b00, 1, 1, 8'hA7, 16'h0); tick(3);
        expect_io("R2 counter refresh lanes idle", 2'b00, 16'h0);
        pins(1, 2'b00, 1, 1, 8'h00, 16'h0); tick(1);
        pins(1, 2'b11, 1, 1, 8'h00, 16'h0); tick(2);
    endtask

    task automatic row_refresh(input logic [7:0] row);
        pins(1, 2'b11, 1, 1, row, 16'h0); tick(1);
        pins(0, 2'b11, 1, 1, row, 16'h0); tick(3);
        expect_io("R3 row-only refresh lanes idle", 2'b00, 16'h0);
        pins(1, 2'b11, 1, 1, row, 16'h0); tick(2);
    endtask

    task automatic write_word(input logic [7:0] row, input logic [7:0] col,
                              input logic [15:0] data, input logic [1:0] lanes);
        pins(1, 2'b11, 1, 1, row, 16'h0); tick(1);
        pins(0, 2'b11, 1, 1, row, 16'h0); tick(2);
        pins(0, ~lanes, 0, 1, col, data); tick(2);
        pins(0, 2'b11, 1, 1, col, 16'h0); tick(1);
        pins(1, 2'b11, 1, 1, 8'h00, 16'h0); tick(2);
    endtask

    task automatic read_word(input string tag, input logic [7:0] row, input logic [7:0] col,
                             input logic [1:0] lanes, input logic oe_v,
                             input logic [1:0] exp_oe, input logic [15:0] exp_dq);
        pins(1, 2'b11, 1, 1, row, 16'h0); tick(1);
        pins(0, 2'b11, 1, 1, row, 16'h0); tick(2);
        pins(0, ~lanes, 1, oe_v, col, 16'h0); tick(3);
        expect_io(tag, exp_oe, exp_dq);
        pins(0, 2'b11, 1, oe_v, col, 16'h0); tick(3);
        expect_io({tag, " strobe released"}, 2'b00, 16'h0);
        pins(1, 2'b11, 1, 1, 8'h00, 16'h0); tick(2);
    endtask

    // watchdog
    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(3);
        expect_io("R1 reset standby", 2'b00, 16'h0);
        expect_miss("R9 reset flag low", 1'b0);

        // window 1: counter rows 0..127, row-only 128..255
        wait_cyc(5);
        for (int i = 0; i < 128; i++) cbr_refresh();
        for (int r = 128; r < 256; r++) row_refresh(8'(r));
        wait_cyc(WIN + 3);
        expect_miss("R9 window 1 fully covered", 1'b0);

        // window 2: counter must continue at 128
        for (int i = 0; i < 128; i++) cbr_refresh();
        for (int r = 0; r < 128; r++) row_refresh(8'(r));
        wait_cyc(2 * WIN + 3);
        expect_miss("R8 counter continues across windows", 1'b0);

        // window 3: counter must have wrapped to 0
        for (int r = 128; r < 256; r++) row_refresh(8'(r));
        for (int i = 0; i < 128; i++) cbr_refresh();
        wait_cyc(3 * WIN + 3);
        expect_miss("R8 counter wraps to zero", 1'b0);

        // window 4: data tests, only a few rows touched
        write_word(8'd2, 8'd5, 16'hA5C3, 2'b11);
        read_word("R5 word write/read", 8'd2, 8'd5, 2'b11, 0, 2'b11, 16'hA5C3);
        read_word("R4 lower lane only", 8'd2, 8'd5, 2'b01, 0, 2'b01, 16'h00C3);
        read_word("R4 upper lane only", 8'd2, 8'd5, 2'b10, 0, 2'b10, 16'hA500);
        write_word(8'd2, 8'd5, 16'h7E99, 2'b10);
        read_word("R5 upper byte write", 8'd2, 8'd5, 2'b11, 0, 2'b11, 16'h7EC3);
        write_word(8'd2, 8'd5, 16'h1111, 2'b01);
        read_word("R5 lower byte write", 8'd2, 8'd5, 2'b11, 0, 2'b11, 16'h7E11);
        read_word("R4 output enable high", 8'd2, 8'd5, 2'b11, 1, 2'b00, 16'h0);

        // R6: page-mode write then page-mode read in row 4
        pins(1, 2'b11, 1, 1, 8'd4, 16'h0); tick(1);
        pins(0, 2'b11, 1, 1, 8'd4, 16'h0); tick(2);
        for (int c = 0; c < 4; c++) begin
            pins(0, 2'b00, 0, 1, 8'(c), 16'h4000 + 16'(c * 16'h0111)); tick(2);
            pins(0, 2'b11, 1, 1, 8'(c), 16'h0); tick(2);
        end
        pins(1, 2'b11, 1, 1, 8'd0, 16'h0); tick(2);
        pins(1, 2'b11, 1, 1, 8'd4, 16'h0); tick(1);
        pins(0, 2'b11, 1, 1, 8'd4, 16'h0); tick(2);
        for (int c = 3; c >= 0; c--) begin
            pins(0, 2'b00, 1, 0, 8'(c), 16'h0); tick(3);
            expect_io("R6 page read column", 2'b11, 16'h4000 + 16'(c * 16'h0111));
            pins(0, 2'b11, 1, 0, 8'(c), 16'h0); tick(3);
            expect_io("R4 page strobe high lanes idle", 2'b00, 16'h0);
        end
        pins(1, 2'b11, 1, 1, 8'd0, 16'h0); tick(2);

        // R2: counter refresh with address on the bus and a write attempt
        pins(1, 2'b00, 1, 1, 8'd2, 16'h0); tick(2);
        pins(0, 2'b00, 1, 1, 8'd2, 16'h0); tick(2);
        pins(0, 2'b11, 1, 1, 8'd5, 16'h0); tick(2);
        pins(0, 2'b00, 0, 1, 8'd5, 16'hFFFF); tick(3);
        expect_io("R2 no drive during counter refresh", 2'b00, 16'h0);
        pins(0, 2'b11, 1, 1, 8'd5, 16'h0); tick(1);
        pins(1, 2'b11, 1, 1, 8'd0, 16'h0); tick(2);
        read_word("R2 counter refresh did not write", 8'd2, 8'd5, 2'b11, 0, 2'b11, 16'h7E11);

        // R7: hidden refresh keeps read data on the pins
        pins(1, 2'b11, 1, 1, 8'd2, 16'h0); tick(1);
        pins(0, 2'b11, 1, 1, 8'd2, 16'h0); tick(2);
        pins(0, 2'b00, 1, 0, 8'd5, 16'h0); tick(3);
        expect_io("R7 read before hidden refresh", 2'b11, 16'h7E11);
        pins(1, 2'b00, 1, 0, 8'd5, 16'h0); tick(3);
        expect_io("R7 row strobe high, data held", 2'b11, 16'h7E11);
        pins(0, 2'b00, 1, 0, 8'd5, 16'h0); tick(3);
        expect_io("R7 hidden refresh data held", 2'b11, 16'h7E11);
        pins(1, 2'b00, 1, 0, 8'd5, 16'h0); tick(1);
        pins(1, 2'b11, 1, 1, 8'd0, 16'h0); tick(3);
        expect_io("R1 standby after hidden refresh", 2'b00, 16'h0);

        wait_cyc(4 * WIN + 3);
        expect_miss("R9 window 4 missed rows", 1'b1);
        tick(4);
        expect_miss("R9 flag stays high", 1'b1);
        tick(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule